// File: doc/BRIEF.md
# Oversampling Serial Receiver with Per-Word Error Queue

This block turns an asynchronous serial line into bytes. It runs on a system clock and is paced by an external oversample tick, which pulses 16, 8 or 4 times per bit period depending on the selected rate. A falling edge on the idle-high line starts a frame. Each bit is sampled near its centre. At the 16x rate three neighbouring samples are taken, and the bit value is their majority. If the three samples do not all agree, the word is marked as noisy.

Each finished word is queued together with three flags: noise, framing and parity. The queue holds up to 128 entries. The host pops the oldest entry with a one-cycle pop strobe. On the next cycle the read outputs show that word's data and its flags, and they hold those values until the next successful pop. A word that arrives while the queue is full is dropped, and a sticky overrun flag is raised. Receive disable blocks new frames but lets the frame already in progress finish. An invert control flips the line polarity before any detection.

Top module: `rx_oversample_fifo`

## Requirements
- R1: While idle and enabled, a tick that sees the line low after the previous tick saw it high starts a frame; that tick is count 0 of the start bit. If the line is high at count `mid` of the start bit (8, 4 or 2 for the 16x, 8x or 4x rate), the start is dropped and no word is stored.
- R2: At the 16x rate (`rate_mode` 00), bits are sampled at counts 7, 8 and 9 of the bit period, and the bit value is the majority of the three samples.
- R3: The noise flag is set when the three samples of any data, parity or stop bit disagree. At the 8x rate (`rate_mode` 01) and the 4x rate (`rate_mode` 1x), one sample is taken at count 4 or count 2, and the noise flag is always 0.
- R4: A frame is a start bit, 8 data bits sent LSB first, an optional parity bit (`parity_en`; even parity, or odd parity when `parity_odd` is 1) and one stop bit. The parity flag is set when the received parity bit does not match the selected parity.
- R5: The framing flag is set when the stop bit is sampled low.
- R6: The word is stored on the tick that decides the stop bit (count 9 at 16x, otherwise count `mid`). `fifo_count` rises by one on that clock edge. The entry holds the data and the three flags.
- R7: A pop on a non-empty queue removes the oldest entry. From the next cycle, `rd_data`, `rd_perr`, `rd_ferr` and `rd_noise` show that entry. A pop on an empty queue changes nothing.
- R8: A word that completes while the queue holds 128 entries is discarded, and `overrun` goes to 1 and stays at 1 until reset.
- R9: While `rx_disable` is 1, no new frame starts. A frame already in progress when it is raised is still completed and stored.
- R10: When `rx_invert` is 1, the line is inverted before edge detection and sampling.
- R11: After reset the queue is empty, and `overrun` and all read outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Serial line, already synchronous to clk |
| os_tick | input | 1 | Oversample tick, one pulse per sub-bit period |
| rate_mode | input | 2 | 00 = 16x, 01 = 8x, 1x = 4x oversampling |
| parity_en | input | 1 | Parity bit present |
| parity_odd | input | 1 | Odd parity when 1, even when 0 |
| rx_disable | input | 1 | Block new frames |
| rx_invert | input | 1 | Invert line polarity |
| pop | input | 1 | Pop oldest queue entry |
| rd_data | output | 8 | Data of last popped word |
| rd_perr | output | 1 | Parity flag of last popped word |
| rd_ferr | output | 1 | Framing flag of last popped word |
| rd_noise | output | 1 | Noise flag of last popped word |
| fifo_count | output | 8 | Number of queued words |
| overrun | output | 1 | Sticky dropped-word flag |

## Verification
Clean frames at each rate set the baseline. Against that baseline, a single flipped sample at count 7 of a data or parity bit shows the majority vote recovering the value. At 16x the same flip must raise the noise flag; at the other rates, where it falls off the single sample point, it must not. Frames with a wrong parity bit or a low stop bit separate the parity flag from the framing flag. Short start pulses at 16x and 4x tell a glitch apart from a real start bit. Disabling mid-frame versus before a frame, an inverted line, and a queue filled past 128 words check the remaining controls. Popping in between checks the oldest-first order and the flags carried with each word.

// File: rtl/rx_oversample_fifo.sv
module rx_oversample_fifo #(
  parameter int DEPTH = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_in,
  input  logic                       os_tick,
  input  logic [1:0]                 rate_mode,
  input  logic                       parity_en,
  input  logic                       parity_odd,
  input  logic                       rx_disable,
  input  logic                       rx_invert,
  input  logic                       pop,
  output logic [7:0]                 rd_data,
  output logic                       rd_perr,
  output logic                       rd_ferr,
  output logic                       rd_noise,
  output logic [$clog2(DEPTH):0]     fifo_count,
  output logic                       overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = 11;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;
  st_t st;

  logic [3:0] cnt, mid, per_last;
  logic [2:0] bidx;
  logic [7:0] shreg;
  logic s0, s1, last_rx, nacc, perr_q;

  wire rxp = rx_in ^ rx_invert;
  wire m16 = (rate_mode == 2'b00);
  assign mid      = m16 ? 4'd8  : (rate_mode == 2'b01 ? 4'd4 : 4'd2);
  assign per_last = m16 ? 4'd15 : (rate_mode == 2'b01 ? 4'd7 : 4'd3);

  wire dec    = m16 ? (cnt == mid + 4'd1) : (cnt == mid);
  wire bitv   = m16 ? ((s0 & s1) | (s0 & rxp) | (s1 & rxp)) : rxp;
  wire bnoise = m16 & ~((s0 == s1) & (s1 == rxp));
  wire push_w = os_tick && (st == S_STOP) && dec;
  wire in_idle = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bidx <= '0; shreg <= '0;
      s0 <= 1'b1; s1 <= 1'b1; last_rx <= 1'b1; nacc <= 1'b0; perr_q <= 1'b0;
    end else if (os_tick) begin
      last_rx <= rxp;
      if (st != S_IDLE) cnt <= (cnt == per_last) ? 4'd0 : cnt + 4'd1;
      if (cnt == mid - 4'd1) s0 <= rxp;
      if (cnt == mid) s1 <= rxp;
      case (st)
        S_IDLE:
          if (!rx_disable && last_rx && !rxp) begin
            st <= S_START; cnt <= 4'd1; nacc <= 1'b0; perr_q <= 1'b0;
          end
        S_START:
          if (cnt == mid && rxp) st <= S_IDLE;
          else if (cnt == per_last) begin st <= S_DATA; bidx <= '0; end
        S_DATA: begin
          if (dec) begin
            shreg <= {bitv, shreg[7:1]};
            nacc  <= nacc | bnoise;
          end
          if (cnt == per_last) begin
            if (bidx == 3'd7) st <= parity_en ? S_PAR : S_STOP;
            else bidx <= bidx + 3'd1;
          end
        end
        S_PAR: begin
          if (dec) begin
            perr_q <= (^shreg) ^ bitv ^ parity_odd;
            nacc   <= nacc | bnoise;
          end
          if (cnt == per_last) st <= S_STOP;
        end
        S_STOP:
          if (dec) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  wire full    = (fifo_count == (AW+1)'(DEPTH));
  wire do_push = push_w && !full;
  wire do_pop  = pop && (fifo_count != '0);
  wire [EW-1:0] entry = {nacc | bnoise, ~bitv, perr_q, shreg};

  always_ff @(posedge clk)
    if (do_push) mem[wp] <= entry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fifo_count <= '0; overrun <= 1'b0;
      {rd_noise, rd_ferr, rd_perr, rd_data} <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop) begin
        rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        {rd_noise, rd_ferr, rd_perr, rd_data} <= mem[rp];
      end
      fifo_count <= fifo_count + (AW+1)'(do_push) - (AW+1)'(do_pop);
      if (push_w && full) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_oversample_fifo_chk.sv
module rx_oversample_fifo_chk #(
  parameter int DEPTH = 128
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   pop,
  input logic                   rx_disable,
  input logic                   push_w,
  input logic                   in_idle,
  input logic [$clog2(DEPTH):0] fifo_count,
  input logic                   overrun,
  input logic [7:0]             rd_data
);
  p_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= DEPTH);
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_w && fifo_count == DEPTH |=> overrun);
  p_push_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_w && !pop && fifo_count < DEPTH |=> fifo_count == $past(fifo_count) + 1'b1);
  p_pop_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push_w && fifo_count != 0 |=> fifo_count == $past(fifo_count) - 1'b1);
  p_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push_w && fifo_count == 0 |=> $stable(rd_data) && fifo_count == 0);
  p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && rx_disable |=> in_idle);
endmodule

bind rx_oversample_fifo rx_oversample_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pop(pop), .rx_disable(rx_disable),
  .push_w(push_w), .in_idle(in_idle), .fifo_count(fifo_count),
  .overrun(overrun), .rd_data(rd_data)
);

// File: tb/tb_rx_oversample_fifo.sv
module tb_rx_oversample_fifo;
  localparam int DEPTH = 128;
  logic clk = 0, rst_n = 0, rx_in = 1, os_tick = 0;
  logic [1:0] rate_mode = 2'b00;
  logic parity_en = 0, parity_odd = 0, rx_disable = 0, rx_invert = 0, pop = 0;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, rd_noise, overrun;
  logic [7:0] fifo_count;

  rx_oversample_fifo #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .os_tick(os_tick),
    .rate_mode(rate_mode), .parity_en(parity_en), .parity_odd(parity_odd),
    .rx_disable(rx_disable), .rx_invert(rx_invert), .pop(pop),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_noise(rd_noise),
    .fifo_count(fifo_count), .overrun(overrun));

  always #5 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 0;
  string cur_req = "R11";
  logic [10:0] q[$];
  logic [10:0] exp_rd = '0;
  logic exp_ovr = 0;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check({rd_noise, rd_ferr, rd_perr, rd_data} == exp_rd, {cur_req, " read"},
          {rd_noise, rd_ferr, rd_perr, rd_data}, exp_rd);
    check(fifo_count == q.size(), {cur_req, " count"}, fifo_count, q.size());
    check(overrun == exp_ovr, {cur_req, " overrun"}, overrun, exp_ovr);
  end

  task automatic tick(input logic lvl, input bit psh, input logic [10:0] ent);
    @(negedge clk);
    rx_in = lvl ^ rx_invert;
    os_tick = 1;
    @(posedge clk);
    #1 os_tick = 0;
    if (psh) begin
      if (q.size() < DEPTH) q.push_back(ent);
      else exp_ovr = 1;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic idle_ticks(input int n);
    for (int i = 0; i < n; i++) tick(1'b1, 0, '0);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                            input int noise_idx, input int dis_at, input bit store);
    int P, mid, decpos, K;
    logic b[11];
    logic [10:0] ent;
    P = (rate_mode == 2'b00) ? 16 : (rate_mode == 2'b01 ? 8 : 4);
    mid = P / 2;
    decpos = (P == 16) ? 9 : mid;
    K = parity_en ? 10 : 9;
    b[0] = 0;
    for (int i = 0; i < 8; i++) b[i+1] = d[i];
    if (parity_en) b[9] = (^d) ^ parity_odd ^ bad_par;
    b[K] = ~bad_stop;
    ent = {(rate_mode == 2'b00) && (noise_idx >= 0), bad_stop, parity_en & bad_par, d};
    for (int bi = 0; bi <= K; bi++)
      for (int c = 0; c < P; c++) begin
        logic lvl;
        lvl = b[bi];
        if (noise_idx >= 0 && bi == noise_idx + 1 && c == mid - 1) lvl = ~lvl;
        if (bi * P + c == dis_at) rx_disable = 1;
        tick(lvl, store && bi == K && c == decpos, ent);
      end
    idle_ticks(2);
  endtask

  task automatic glitch_start();
    int P;
    P = (rate_mode == 2'b00) ? 16 : (rate_mode == 2'b01 ? 8 : 4);
    for (int c = 0; c < P / 2; c++) tick(1'b0, 0, '0);
    idle_ticks(P * 12);
  endtask

  task automatic do_pop();
    @(negedge clk);
    pop = 1;
    @(posedge clk);
    #1 pop = 0;
    if (q.size() > 0) exp_rd = q.pop_front();
  endtask

  task automatic drain();
    while (q.size() > 0) do_pop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(fifo_count == 0 && overrun == 0 && rd_data == 0 && !rd_perr && !rd_ferr && !rd_noise,
          "R11 reset state", {overrun, rd_data}, 0);
    rst_n = 1;
    idle_ticks(3);

    cur_req = "R2 R6 clean 16x";
    send_frame(8'hA5, 0, 0, -1, -1, 1);
    cur_req = "R2 R3 noise 16x";
    send_frame(8'h3C, 0, 0, 2, -1, 1);
    cur_req = "R4 parity even ok";
    parity_en = 1;
    send_frame(8'h0F, 0, 0, -1, -1, 1);
    cur_req = "R4 parity odd bad";
    parity_odd = 1;
    send_frame(8'h81, 1, 0, -1, -1, 1);
    cur_req = "R3 noise on parity";
    send_frame(8'h5A, 0, 0, 8, -1, 1);
    cur_req = "R5 framing";
    parity_en = 0; parity_odd = 0;
    send_frame(8'hC3, 0, 1, -1, -1, 1);
    idle_ticks(2);
    cur_req = "R7 pop order";
    drain();
    cur_req = "R7 pop empty";
    do_pop(); do_pop();

    cur_req = "R3 8x no noise";
    rate_mode = 2'b01;
    send_frame(8'h96, 0, 0, 1, -1, 1);
    cur_req = "R3 4x no noise";
    rate_mode = 2'b10;
    send_frame(8'h6E, 0, 0, 3, -1, 1);
    cur_req = "R1 glitch 4x";
    glitch_start();
    cur_req = "R1 glitch 16x";
    rate_mode = 2'b00;
    glitch_start();
    cur_req = "R1 start after glitch";
    send_frame(8'h11, 0, 0, -1, -1, 1);
    cur_req = "R7 pop order";
    drain();

    cur_req = "R9 disable mid-frame";
    send_frame(8'h2D, 0, 0, -1, 48, 1);
    cur_req = "R9 disabled frame dropped";
    send_frame(8'hF0, 0, 0, -1, -1, 0);
    rx_disable = 0;
    idle_ticks(2);
    cur_req = "R10 inverted line";
    rx_invert = 1;
    idle_ticks(2);
    send_frame(8'h4B, 0, 0, 4, -1, 1);
    rx_invert = 0;
    idle_ticks(2);
    drain();

    cur_req = "R8 fill and overrun";
    rate_mode = 2'b10;
    for (int i = 0; i < DEPTH + 2; i++) send_frame(8'(i * 7 + 3), 0, 0, -1, -1, 1);
    check(fifo_count == DEPTH, "R8 full count", fifo_count, DEPTH);
    check(overrun == 1, "R8 overrun set", overrun, 1);
    cur_req = "R8 oldest kept";
    do_pop();
    check(rd_data == 8'h03, "R8 oldest word", rd_data, 3);
    do_pop();
    idle_ticks(2);
    check(overrun == 1, "R8 overrun sticky", overrun, 1);

    finish_run();
  end
endmodule